// File: doc/BRIEF.md
# Soft-Stepping Volume Gain Controller

The block holds a 6-bit gain code that a host writes and produces the "actual" gain code that drives an analog attenuator. When soft transition is enabled, a change of the requested code does not reach the output at once. The block opens a timed window of 256, 512, 1024 or 2048 sample periods, counted on a sample-rate tick. At the end of the window the output takes the target that was latched when the window opened. The block then compares the output with the request again. If they still differ, because the host wrote during the window, it opens another window toward the latest request.

Two overrides switch soft transition off. The first is standby, which forces the output to 0 dB (code 0x1F) and leaves the stored request alone. The second is converter power-down, in which the output follows the request directly. When standby is released with soft transition enabled, the block opens a window from 0 dB toward the stored request if the two differ.

Top module: `soft_gain_stepper`

## Requirements
- R1: After reset the gain output is 0x1F (0 dB) and busy is low.
- R2: A write stores the written code. Codes 0x23 to 0x3F are reserved, and a write of any of them stores 0x22 (+6 dB) instead.
- R3: With soft transition disabled and neither override asserted, the gain output takes the written code on the second rising clock edge after the write strobe, and busy stays low.
- R4: With soft transition active and no window open, a difference between the output and the stored request sets busy on the next clock edge. The gain output holds its value for the whole window. On the edge that accepts the last tick of the window, the output updates to the latched target and busy falls.
- R5: A write made during a window does not change that window's target. On the clock edge after the window ends, a new window opens toward the latest request if it differs from the output.
- R6: While standby is asserted, the gain output is 0x1F, busy is low and the stored request is kept, including writes made during standby. On release with soft transition enabled, a window opens toward the stored request if it differs from 0x1F.
- R7: While converter power-down is asserted, soft transition is off: busy is low and the gain output follows the request as in R3.
- R8: The window length in sample ticks is 256 << sel, with sel the 2-bit window select sampled when the window opens: 0 gives 256, 1 gives 512, 2 gives 1024 and 3 gives 2048.
- R9: Code 0x00 (mute) and code 0x01 (-60 dB) are stored and output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the requested gain code |
| wr_code | input | 6 | Requested gain code |
| soft_en | input | 1 | Soft transition enable |
| win_sel | input | 2 | Window select, 256 << win_sel sample ticks |
| fs_tick | input | 1 | One-cycle pulse per sample period |
| hold_unity | input | 1 | Standby override: force 0 dB |
| conv_off | input | 1 | Converter power-down: soft transition off |
| gain_out | output | 6 | Actual gain code |
| busy | output | 1 | High while a transition window is open |

## Verification
The hardest case to reach from the ports is a host write that lands inside an open window. The stimulus first lets a window run for about a hundred ticks and then writes a second code. The checks confirm that the output still lands on the first target, and that a second window toward the newer code opens on the very next clock edge. Standby is also asserted in the middle of a configuration where the request differs from 0 dB, with a further write during standby, so that the release has to start a window from the forced value. The bench counts the sample ticks while busy is high and compares the count with 256 << sel for all four select values.

// File: rtl/sgs_pkg.sv
package sgs_pkg;
   localparam int GAIN_W = 6;
   typedef logic [GAIN_W-1:0] gain_t;
   localparam gain_t CODE_UNITY = 6'h1F;
   localparam gain_t CODE_TOP   = 6'h22;

   function automatic gain_t limit_code(input gain_t c, input gain_t top);
      return (c > top) ? top : c;
   endfunction
endpackage

// File: rtl/sgs_req_reg.sv
module sgs_req_reg
   import sgs_pkg::*;
#(
   parameter gain_t RST_CODE  = CODE_UNITY,
   parameter gain_t MAX_CODE  = CODE_TOP,
   parameter bit    CLAMP_HI  = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_en,
   input  gain_t wr_code,
   output gain_t req_q
);
   gain_t next_code;

   initial begin
      assert (RST_CODE <= MAX_CODE) else $error("reset code above the top code");
   end

   generate
      if (CLAMP_HI) begin : g_clamp
         assign next_code = limit_code(wr_code, MAX_CODE);
      end else begin : g_drop
         assign next_code = (wr_code > MAX_CODE) ? req_q : wr_code;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     req_q <= RST_CODE;
      else if (wr_en) req_q <= next_code;
   end

   AST_RESERVED_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_code > MAX_CODE && CLAMP_HI) |=> (req_q == MAX_CODE)); // R2

   AST_PLAIN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_code <= MAX_CODE) |=> (req_q == $past(wr_code))); // R9
endmodule

// File: rtl/sgs_window_timer.sv
module sgs_window_timer #(
   parameter int BASE_LOG2 = 8,
   parameter int SEL_W     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             abort,
   input  logic             tick,
   input  logic [SEL_W-1:0] sel,
   output logic             busy,
   output logic             done
);
   localparam int NSEL  = 1 << SEL_W;
   localparam int CNT_W = BASE_LOG2 + NSEL - 1;

   logic [CNT_W-1:0] cnt_q;
   logic [SEL_W-1:0] sel_q;
   logic [CNT_W-1:0] last_val [NSEL];

   initial begin
      assert (BASE_LOG2 >= 1) else $error("window base must be at least 2 ticks");
      assert (SEL_W >= 1 && SEL_W <= 3) else $error("window select width out of range");
   end

   genvar g;
   generate
      for (g = 0; g < NSEL; g++) begin : g_lim
         localparam logic [CNT_W:0] LEN = (CNT_W+1)'(1) << (BASE_LOG2 + g);
         assign last_val[g] = CNT_W'(LEN - 1'b1);
      end
   endgenerate

   assign done = busy && tick && (cnt_q == last_val[sel_q]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
         sel_q <= '0;
      end else if (abort) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (start && !busy) begin
         busy  <= 1'b1;
         cnt_q <= '0;
         sel_q <= sel;
      end else if (done) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (busy && tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt_q <= last_val[sel_q])); // R8

   AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !abort) |=> !busy); // R4

   AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(sel_q)); // R8
endmodule

// File: rtl/soft_gain_stepper.sv
module soft_gain_stepper
   import sgs_pkg::*;
#(
   parameter int BASE_LOG2 = 8,
   parameter int SEL_W     = 2,
   parameter bit CLAMP_HI  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [5:0]       wr_code,
   input  logic             soft_en,
   input  logic [SEL_W-1:0] win_sel,
   input  logic             fs_tick,
   input  logic             hold_unity,
   input  logic             conv_off,
   output logic [5:0]       gain_out,
   output logic             busy
);
   gain_t req_q;
   gain_t tgt_q;
   gain_t act_q;
   gain_t eff_code;
   logic  soft_act;
   logic  win_start;
   logic  win_done;

   sgs_req_reg #(
      .RST_CODE (CODE_UNITY),
      .MAX_CODE (CODE_TOP),
      .CLAMP_HI (CLAMP_HI)
   ) i_req (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_code (wr_code),
      .req_q   (req_q)
   );

   assign soft_act  = soft_en && !hold_unity && !conv_off;
   assign eff_code  = hold_unity ? CODE_UNITY : req_q;
   assign win_start = soft_act && !busy && (act_q != req_q);

   sgs_window_timer #(
      .BASE_LOG2 (BASE_LOG2),
      .SEL_W     (SEL_W)
   ) i_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (win_start),
      .abort (!soft_act),
      .tick  (fs_tick),
      .sel   (win_sel),
      .busy  (busy),
      .done  (win_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= CODE_UNITY;
         tgt_q <= CODE_UNITY;
      end else begin
         if (win_start) tgt_q <= req_q;
         if (!soft_act)     act_q <= eff_code;
         else if (win_done) act_q <= tgt_q;
      end
   end

   assign gain_out = act_q;

   AST_STABLE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(gain_out)); // R4

   AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(tgt_q)); // R5

   AST_HOLD_UNITY: assert property (@(posedge clk) disable iff (!rst_n)
      hold_unity |=> (gain_out == CODE_UNITY && !busy)); // R6

   AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      conv_off |=> !busy); // R7

   AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (gain_out <= CODE_TOP)); // R2
endmodule

// File: tb/test_soft_gain_stepper.sv
module test_soft_gain_stepper;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [5:0] wr_code = '0;
   logic       soft_en = 1'b0;
   logic [1:0] win_sel = '0;
   logic       fs_tick = 1'b0;
   logic       hold_unity = 1'b0;
   logic       conv_off = 1'b0;
   logic [5:0] gain_out;
   logic       busy;

   int n_chk = 0;
   int n_bad = 0;
   int ticks_seen = 0;
   bit finished = 1'b0;

   soft_gain_stepper i_soft_gain_stepper (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_code(wr_code),
      .soft_en(soft_en), .win_sel(win_sel), .fs_tick(fs_tick),
      .hold_unity(hold_unity), .conv_off(conv_off),
      .gain_out(gain_out), .busy(busy)
   );

   always #4 clk = ~clk;

   initial begin
      int div = 0;
      forever begin
         @(negedge clk);
         fs_tick = (div == 3);
         div = (div + 1) % 4;
      end
   end

   always @(posedge clk) if (busy && fs_tick) ticks_seen <= ticks_seen + 1;

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic write_code(input logic [5:0] c);
      @(negedge clk); wr_en = 1'b1; wr_code = c;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic wait_idle();
      int guard = 0;
      while (busy && guard < 20000) begin @(negedge clk); guard++; end
   endtask

   task automatic t_reset();
      check("R1 gain after reset", gain_out, 6'h1F);
      check("R1 busy after reset", busy, 0);
   endtask

   task automatic t_direct();
      soft_en = 1'b0;
      write_code(6'h10); @(negedge clk);
      check("R3 direct gain", gain_out, 6'h10);
      check("R3 direct busy", busy, 0);
      write_code(6'h2A); @(negedge clk);
      check("R2 reserved clamp", gain_out, 6'h22);
      write_code(6'h3F); @(negedge clk);
      check("R2 top reserved clamp", gain_out, 6'h22);
      write_code(6'h00); @(negedge clk);
      check("R9 mute code", gain_out, 6'h00);
      write_code(6'h01); @(negedge clk);
      check("R9 lowest code", gain_out, 6'h01);
   endtask

   task automatic t_soft_window(input logic [1:0] s, input logic [5:0] c, input logic [5:0] prev);
      int t0;
      win_sel = s;
      t0 = ticks_seen;
      write_code(c); @(negedge clk);
      check("R4 busy opens", busy, 1);
      repeat (200) @(negedge clk);
      check("R4 gain held in window", gain_out, prev);
      wait_idle();
      check("R4 gain at window end", gain_out, c);
      check("R8 window length", ticks_seen - t0, 256 << s);
   endtask

   task automatic t_midwrite();
      win_sel = 2'd0;
      write_code(6'h10); @(negedge clk);
      check("R5 first window open", busy, 1);
      repeat (400) @(negedge clk);
      write_code(6'h05);
      check("R5 still busy after write", busy, 1);
      check("R5 gain unchanged by write", gain_out, 6'h1F);
      wait_idle();
      check("R5 first target reached", gain_out, 6'h10);
      @(negedge clk);
      check("R5 second window opens", busy, 1);
      wait_idle();
      check("R5 latest request reached", gain_out, 6'h05);
   endtask

   task automatic t_standby();
      @(negedge clk); hold_unity = 1'b1;
      @(negedge clk);
      check("R6 forced unity", gain_out, 6'h1F);
      check("R6 busy low", busy, 0);
      write_code(6'h08); @(negedge clk);
      check("R6 write in standby ignored at output", gain_out, 6'h1F);
      hold_unity = 1'b0;
      @(negedge clk);
      check("R6 window on release", busy, 1);
      check("R6 gain still unity", gain_out, 6'h1F);
      wait_idle();
      check("R6 stored request reached", gain_out, 6'h08);
   endtask

   task automatic t_convoff();
      @(negedge clk); conv_off = 1'b1;
      write_code(6'h12); @(negedge clk);
      check("R7 direct under power-down", gain_out, 6'h12);
      check("R7 busy low", busy, 0);
      conv_off = 1'b0;
      repeat (3) @(negedge clk);
      check("R7 no window when equal", busy, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_direct();
      soft_en = 1'b1;
      @(negedge clk);
      t_soft_window(2'd0, 6'h1F, 6'h01);
      t_soft_window(2'd1, 6'h0A, 6'h1F);
      t_soft_window(2'd2, 6'h14, 6'h0A);
      t_soft_window(2'd3, 6'h1F, 6'h14);
      t_midwrite();
      t_standby();
      t_convoff();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule